// File: doc/BRIEF.md
# Serial Register Loader with Deferred Update

This block accepts register writes from a three-wire serial link (frame strobe, serial clock, serial data) and places them in a small, parameterised register file. A frame opens with a 12-bit address and then carries one or more 28-bit data words. Each word goes to one address higher than the word before it, so one address phase can fill a run of registers.

Each register has a shadow copy and an active copy, and only the active copy appears at the outputs. A per-register update class, fixed by a parameter, decides when a written value reaches the active copy:
- at once;
- on the next falling edge of the vertical sync input;
- on the next rising edge of the sensor-control-point boundary input.

One register holds an enable mask. Each bit of the mask moves one register of a timing group to update on the vertical sync rising edge instead.

All serial and timing inputs are synchronised to the system clock inside the block. The serial clock must therefore be much slower than the system clock.

Top module: `serial_shadow_regs`

## Requirements
- R1: After reset every active register reads 0 and no update is pending.
- R2: While the frame strobe `sl_i` is low, one bit of `sdi_i` is taken on each rising edge of `sck_i`, least significant bit first. The first 12 bits form the start address, and each following group of 28 bits forms one data word.
- R3: The first word of a frame is written to the start address. Each further word of the same frame is written to the previous word's address plus one.
- R4: When `sl_i` rises, any incomplete word or address is thrown away and the next frame begins with a new address phase.
- R5: Only bits [15:0] of a word are stored. A word whose address is 8 or more has no effect on any register; this includes the pattern memory region at 0x800 and above.
- R6: Registers 0, 1, 2 and 7 are of the immediate class. When one of them is not masked, its active value takes the new word as soon as the word is complete.
- R7: Registers 3 and 6 are of the vertical-sync class. A write to one of them (when not masked) keeps its old active value until the next falling edge of `vd_i`, and then takes the written value.
- R8: Registers 4 and 5 are of the boundary class. A write to one of them (when not masked) keeps its old active value until the next rising edge of `scp_i`. A `vd_i` edge does not apply it.
- R9: Register 7 is the mask. When bit k of its active value is 1, register 2+k (k = 0..3) ignores its own class. A write to that register is then applied only on the next rising edge of `vd_i`, and a falling edge of `vd_i` leaves it pending.
- R10: A second write before the pending update is applied replaces the pending value, so the update applies the newest word. An update event with nothing pending leaves the active value unchanged.
- R11: When a word completes for a deferred register in the same cycle as that register's update event, the event applies the older pending value. The new word stays pending until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sl_i | input | 1 | Frame strobe; low while a frame is sent |
| sck_i | input | 1 | Serial bit clock; data is taken on its rising edge |
| sdi_i | input | 1 | Serial data, least significant bit first |
| vd_i | input | 1 | Vertical sync; falling and rising edges are update events |
| scp_i | input | 1 | Sensor-control-point boundary; rising edge is an update event |
| act_o | output | NREGS*REG_W (128) | Active register values; register i occupies bits [16*i+15:16*i] |

## Verification
The completion of a data word and the update event of its own register can fall in the same system clock cycle, and this is the case that needs care. The bench provokes it by raising the serial clock for the final data bit and dropping the vertical sync input in the same instant. Both inputs then pass through identical synchronisers and reach the register cell together. The bench judges the result by checking two things: the active value right after the event must be the older pending word, and the newer word must appear only after the following vertical sync falling edge.

// File: rtl/regload_pkg.sv
`timescale 1ns/1ps
package regload_pkg;
   typedef enum logic [1:0] {
      UPD_NOW = 2'd0,
      UPD_VDF = 2'd1,
      UPD_SCP = 2'd2
   } upd_cls_e;

   localparam int NUM_SYNC_IN = 5;
endpackage

// File: rtl/rl_serial_rx.sv
`timescale 1ns/1ps
module rl_serial_rx #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 28
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sl,
   input  logic              sck_rise,
   input  logic              sdi,
   output logic              wr_valid,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data
);
   localparam int MAXW  = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
   localparam int CNT_W = $clog2(MAXW);

   generate
      if (ADDR_W < 2 || DATA_W < 2) begin : g_bad_width
         $error("rl_serial_rx: widths must be at least 2");
      end
   endgenerate

   logic              in_data;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_sh;
   logic [ADDR_W-1:0] addr_cur;
   logic [DATA_W-1:0] data_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_data  <= 1'b0;
         cnt      <= '0;
         addr_sh  <= '0;
         addr_cur <= '0;
         data_sh  <= '0;
         wr_valid <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_valid <= 1'b0;
         if (sl) begin
            in_data <= 1'b0;
            cnt     <= '0;
         end else if (sck_rise) begin
            if (!in_data) begin
               addr_sh <= {sdi, addr_sh[ADDR_W-1:1]};
               if (cnt == CNT_W'(ADDR_W-1)) begin
                  in_data  <= 1'b1;
                  cnt      <= '0;
                  addr_cur <= {sdi, addr_sh[ADDR_W-1:1]};
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end else begin
               data_sh <= {sdi, data_sh[DATA_W-1:1]};
               if (cnt == CNT_W'(DATA_W-1)) begin
                  cnt      <= '0;
                  wr_valid <= 1'b1;
                  wr_data  <= {sdi, data_sh[DATA_W-1:1]};
                  wr_addr  <= addr_cur;
                  addr_cur <= addr_cur + 1'b1;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
         end
      end
   end

   // R3: after a word, the address for the next word is one higher
   a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> (addr_cur == wr_addr + 1'b1));

   // R4: a high strobe clears the frame state and emits no word
   a_r4_sl_flush: assert property (@(posedge clk) disable iff (!rst_n)
      sl |=> (cnt == '0 && !in_data && !wr_valid));
endmodule

// File: rtl/rl_upd_cell.sv
`timescale 1ns/1ps
module rl_upd_cell
   import regload_pkg::*;
#(
   parameter int       REG_W = 16,
   parameter upd_cls_e CLS   = UPD_NOW
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_hit,
   input  logic [REG_W-1:0] wr_val,
   input  logic             masked,
   input  logic             ev_cls,
   input  logic             ev_vdr,
   output logic [REG_W-1:0] act
);
   logic [REG_W-1:0] shd;
   logic             pend;
   logic             deferred;
   logic             ev;

   assign deferred = masked || (CLS != UPD_NOW);
   assign ev       = masked ? ev_vdr : ev_cls;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act  <= '0;
         shd  <= '0;
         pend <= 1'b0;
      end else begin
         if (ev && pend) act <= shd;
         if (wr_hit) begin
            shd <= wr_val;
            if (deferred) begin
               pend <= 1'b1;
            end else begin
               act  <= wr_val;
               pend <= 1'b0;
            end
         end else if (ev) begin
            pend <= 1'b0;
         end
      end
   end

   // R6: an immediate write shows on the active copy in the next cycle
   a_r6_now_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && !deferred) |=> (act == $past(wr_val)));

   // R10: without a write or an event the active copy holds
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_hit && !ev) |=> $stable(act));

   // R11: a coincident event applies the older shadow, the new word stays pending
   a_r11_coincide: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hit && deferred && ev && pend) |=> (act == $past(shd) && pend));
endmodule

// File: rtl/serial_shadow_regs.sv
`timescale 1ns/1ps
module serial_shadow_regs
   import regload_pkg::*;
#(
   parameter int                   ADDR_W      = 12,
   parameter int                   DATA_W      = 28,
   parameter int                   REG_W       = 16,
   parameter int                   NREGS       = 8,
   parameter logic [2*NREGS-1:0]   CLASS_MAP   = 16'h1A40,
   parameter int                   MASK_ADDR   = 7,
   parameter int                   TG_BASE     = 2,
   parameter int                   TG_CNT      = 4,
   parameter int                   SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   sl_i,
   input  logic                   sck_i,
   input  logic                   sdi_i,
   input  logic                   vd_i,
   input  logic                   scp_i,
   output logic [NREGS*REG_W-1:0] act_o
);
   localparam logic [NUM_SYNC_IN-1:0] SYNC_RST = 5'b01001;

   generate
      if (REG_W > DATA_W || REG_W < TG_CNT) begin : g_bad_regw
         $error("serial_shadow_regs: REG_W out of range");
      end
      if (NREGS > (1 << ADDR_W) || NREGS < 1) begin : g_bad_nregs
         $error("serial_shadow_regs: NREGS does not fit the address space");
      end
      if (TG_CNT < 1 || TG_CNT > 16 || TG_BASE + TG_CNT > NREGS) begin : g_bad_tg
         $error("serial_shadow_regs: timing group out of range");
      end
      if (MASK_ADDR >= NREGS || (MASK_ADDR >= TG_BASE && MASK_ADDR < TG_BASE + TG_CNT)) begin : g_bad_mask
         $error("serial_shadow_regs: mask register misplaced");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("serial_shadow_regs: at least two sync stages required");
      end
   endgenerate

   // ---------------- input synchronisers ----------------
   logic [NUM_SYNC_IN-1:0] raw_in;
   logic [NUM_SYNC_IN-1:0] syn;
   assign raw_in = {scp_i, vd_i, sdi_i, sck_i, sl_i};

   for (genvar b = 0; b < NUM_SYNC_IN; b++) begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain <= {SYNC_STAGES{SYNC_RST[b]}};
         else        chain <= {chain[SYNC_STAGES-2:0], raw_in[b]};
      end
      assign syn[b] = chain[SYNC_STAGES-1];
   end

   logic sl_s, sck_s, sdi_s, vd_s, scp_s;
   assign {scp_s, vd_s, sdi_s, sck_s, sl_s} = syn;

   logic sck_d, vd_d, scp_d;
   logic ev_vdf_q, ev_vdr_q, ev_scp_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck_d    <= SYNC_RST[1];
         vd_d     <= SYNC_RST[3];
         scp_d    <= SYNC_RST[4];
         ev_vdf_q <= 1'b0;
         ev_vdr_q <= 1'b0;
         ev_scp_q <= 1'b0;
      end else begin
         sck_d    <= sck_s;
         vd_d     <= vd_s;
         scp_d    <= scp_s;
         ev_vdf_q <= vd_d & ~vd_s;
         ev_vdr_q <= ~vd_d & vd_s;
         ev_scp_q <= ~scp_d & scp_s;
      end
   end

   // ---------------- serial receiver ----------------
   logic              wr_valid;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   rl_serial_rx #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sl       (sl_s),
      .sck_rise (sck_s & ~sck_d),
      .sdi      (sdi_s),
      .wr_valid (wr_valid),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data)
   );

   logic [REG_W-1:0] wr_val;
   assign wr_val = wr_data[REG_W-1:0];
   generate
      if (DATA_W > REG_W) begin : g_drop_hi
         logic unused_hi;
         assign unused_hi = ^wr_data[DATA_W-1:REG_W];
      end
   endgenerate

   // ---------------- register file ----------------
   logic [NREGS-1:0]  hit;
   logic [TG_CNT-1:0] mask_bits;
   assign mask_bits = act_o[MASK_ADDR*REG_W +: TG_CNT];

   for (genvar i = 0; i < NREGS; i++) begin : g_reg
      localparam upd_cls_e CLS_I = upd_cls_e'(CLASS_MAP[2*i +: 2]);
      logic masked_i;
      logic ev_cls_i;

      assign hit[i] = wr_valid && (wr_addr == ADDR_W'(i));

      if (i >= TG_BASE && i < TG_BASE + TG_CNT) begin : g_tg
         assign masked_i = mask_bits[i-TG_BASE];
      end else begin : g_plain
         assign masked_i = 1'b0;
      end

      if (CLS_I == UPD_VDF) begin : g_vdf
         assign ev_cls_i = ev_vdf_q;
      end else if (CLS_I == UPD_SCP) begin : g_scp
         assign ev_cls_i = ev_scp_q;
      end else begin : g_now
         assign ev_cls_i = 1'b0;
      end

      rl_upd_cell #(.REG_W(REG_W), .CLS(CLS_I)) u_cell (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (hit[i]),
         .wr_val (wr_val),
         .masked (masked_i),
         .ev_cls (ev_cls_i),
         .ev_vdr (ev_vdr_q),
         .act    (act_o[i*REG_W +: REG_W])
      );
   end

   // R5: a word reaches at most one register, and none when out of range
   a_r5_one_target: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));

   a_r5_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid && wr_addr >= ADDR_W'(NREGS)) |-> (hit == '0));
endmodule

// File: tb/test_serial_shadow_regs.sv
`timescale 1ns/1ps
module test_serial_shadow_regs;
   localparam int NR = 8;
   localparam int RW = 16;
   localparam int EV_FALL = 0;
   localparam int EV_RISE = 1;
   localparam int EV_SCP  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sl = 1'b1, sck = 1'b0, sdi = 1'b0, vd = 1'b1, scp = 1'b0;
   logic [NR*RW-1:0] act;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [15:0] act_m [NR];
   logic [15:0] shd_m [NR];
   bit          pend_m [NR];
   logic [27:0] wdat [4];

   always #4 clk = ~clk;

   serial_shadow_regs i_serial_shadow_regs (
      .clk(clk), .rst_n(rst_n), .sl_i(sl), .sck_i(sck), .sdi_i(sdi),
      .vd_i(vd), .scp_i(scp), .act_o(act)
   );

   function automatic int cls_of(int i);
      case (i)
         3, 6:    return 1;
         4, 5:    return 2;
         default: return 0;
      endcase
   endfunction

   function automatic bit masked_of(int i);
      if (i >= 2 && i < 6) return act_m[7][i-2];
      return 1'b0;
   endfunction

   function automatic void m_write(int a, logic [27:0] d);
      if (a < NR) begin
         if (masked_of(a) || cls_of(a) != 0) begin
            shd_m[a] = d[15:0];
            pend_m[a] = 1'b1;
         end else begin
            act_m[a] = d[15:0];
            shd_m[a] = d[15:0];
            pend_m[a] = 1'b0;
         end
      end
   endfunction

   function automatic void m_event(int kind);
      for (int i = 0; i < NR; i++) begin
         bit e;
         if (masked_of(i)) e = (kind == EV_RISE);
         else e = (cls_of(i) == 1 && kind == EV_FALL) || (cls_of(i) == 2 && kind == EV_SCP);
         if (e && pend_m[i]) begin
            act_m[i] = shd_m[i];
            pend_m[i] = 1'b0;
         end
      end
   endfunction

   task automatic tick(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check_all(string tag);
      for (int i = 0; i < NR; i++) begin
         logic [15:0] got;
         got = act[i*RW +: RW];
         checks++;
         if (got !== act_m[i]) begin
            errors++;
            $display("FAIL %s reg%0d: actual %h expected %h", tag, i, got, act_m[i]);
         end
      end
   endtask

   task automatic send_bit(logic b, bit coin);
      sdi = b;
      tick(3);
      sck = 1'b1;
      if (coin) vd = 1'b0;
      tick(3);
      sck = 1'b0;
   endtask

   // nw words from wdat; extra partial bits; coin drops vd with the last data bit
   task automatic frame(logic [11:0] a, int nw, int extra, bit coin);
      sl = 1'b0;
      tick(3);
      for (int k = 0; k < 12; k++) send_bit(a[k], 1'b0);
      for (int w = 0; w < nw; w++) begin
         for (int k = 0; k < 28; k++)
            send_bit(wdat[w][k], coin && (w == nw - 1) && (k == 27));
         if (coin && w == nw - 1) m_event(EV_FALL);
         m_write(int'(a) + w, wdat[w]);
      end
      for (int k = 0; k < extra; k++) send_bit(1'($urandom_range(0, 1)), 1'b0);
      tick(3);
      sl = 1'b1;
      tick(8);
   endtask

   task automatic vd_fall();
      vd = 1'b0; tick(8); m_event(EV_FALL);
   endtask

   task automatic vd_rise();
      vd = 1'b1; tick(8); m_event(EV_RISE);
   endtask

   task automatic scp_pulse();
      scp = 1'b1; tick(8); m_event(EV_SCP);
      scp = 1'b0; tick(8);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < NR; i++) begin act_m[i] = '0; shd_m[i] = '0; pend_m[i] = 1'b0; end
      tick(4);
      rst_n = 1'b1;
      tick(6);
      check_all("R1 reset");

      // R2 R6: single word, LSB first
      wdat[0] = 28'hABC1234;
      frame(12'h000, 1, 0, 1'b0);
      check_all("R2 R6 single word");

      // R3: burst of three words from address 0
      wdat[0] = 28'h0001111; wdat[1] = 28'h0002222; wdat[2] = 28'h0003333;
      frame(12'h000, 3, 0, 1'b0);
      check_all("R3 auto-increment");

      // R5: high bits dropped, out-of-range address ignored
      wdat[0] = 28'hFFF5A5A;
      frame(12'h001, 1, 0, 1'b0);
      wdat[0] = 28'h000BEEF;
      frame(12'h800, 1, 0, 1'b0);
      frame(12'h008, 1, 0, 1'b0);
      check_all("R5 truncation and range");

      // R7: vd-class register
      wdat[0] = 28'h0007777;
      frame(12'h003, 1, 0, 1'b0);
      check_all("R7 held after write");
      scp_pulse();
      check_all("R7 boundary does not apply");
      vd_fall();
      check_all("R7 applied on vd fall");
      vd_rise();

      // R8: boundary-class register
      wdat[0] = 28'h0004444;
      frame(12'h004, 1, 0, 1'b0);
      vd_fall(); vd_rise();
      check_all("R8 vd does not apply");
      scp_pulse();
      check_all("R8 applied on boundary");

      // R10: newest pending value wins; empty event changes nothing
      wdat[0] = 28'h0006001;
      frame(12'h006, 1, 0, 1'b0);
      wdat[0] = 28'h0006002;
      frame(12'h006, 1, 0, 1'b0);
      vd_fall();
      check_all("R10 newest value applied");
      vd_rise(); vd_fall();
      check_all("R10 empty event");
      vd_rise();

      // R4: partial word and partial address discarded
      wdat[0] = 28'h0000A0A; wdat[1] = 28'h0000B0B;
      frame(12'h000, 1, 20, 1'b0);
      frame(12'h001, 0, 5, 1'b0);
      wdat[0] = 28'h0000C0C;
      frame(12'h001, 1, 0, 1'b0);
      check_all("R4 partial discarded");

      // R9: mask moves register 2 and register 3 to vd rising edge
      wdat[0] = 28'h0000003;
      frame(12'h007, 1, 0, 1'b0);
      wdat[0] = 28'h0002020; wdat[1] = 28'h0003030;
      frame(12'h002, 2, 0, 1'b0);
      check_all("R9 masked held");
      vd_fall();
      check_all("R9 vd fall ignored when masked");
      vd_rise();
      check_all("R9 applied on vd rise");
      wdat[0] = 28'h0000000;
      frame(12'h007, 1, 0, 1'b0);
      check_all("R9 mask cleared");

      // R11: word completion and vd fall in the same cycle
      wdat[0] = 28'h000AAAA;
      frame(12'h003, 1, 0, 1'b0);
      wdat[0] = 28'h000BBBB;
      frame(12'h003, 1, 0, 1'b1);
      check_all("R11 older value applied");
      vd_rise();
      vd_fall();
      check_all("R11 newer value on next event");
      vd_rise();

      // random mix
      for (int it = 0; it < 90; it++) begin
         int op;
         op = $urandom_range(0, 5);
         if (op <= 2) begin
            int nw;
            nw = $urandom_range(1, 3);
            for (int w = 0; w < nw; w++) wdat[w] = 28'($urandom);
            frame(12'($urandom_range(0, 9)), nw, ($urandom_range(0, 3) == 0) ? $urandom_range(1, 27) : 0, 1'b0);
         end else if (op == 3) begin
            vd_fall(); check_all("random R7 R9 event"); vd_rise();
         end else begin
            scp_pulse();
         end
         check_all("random R6 R8 R10");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule